// File: doc/BRIEF.md
# Register Rename Map with Free Pool

This block gives every instruction that writes a register its own physical register, so that later writes to the same architectural name no longer have to wait for earlier reads or writes of that name. Each cycle one instruction in decode order may be presented. The block looks up the physical names of its two sources in a map with one entry per architectural register. It then takes an unused physical register from a free pool for the destination and points the map entry at it.

The block returns the renamed sources and the new destination tag. It also returns the physical register that the destination used to map to, which a reorder buffer keeps in case the instruction has to be undone. When an instruction commits, the reorder buffer hands back that displaced register and it goes back into the pool. On a squash the reorder buffer replays its saved pairs one per cycle, youngest first. Each replay puts the old mapping back into the map and returns the register that the squashed instruction had taken.

All rename outputs are combinational from the current map and pool. Map and pool updates take effect at the next clock edge.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and physical registers ARCH_REGS to PHYS_REGS-1 are free.
- R2: Source tags are read from the map as it stood before this instruction's own destination update. An instruction that reads and writes the same register sees the previous mapping for that source.
- R3: A renamed instruction with a destination receives the lowest-numbered free physical register on `dstPhys`. From the next cycle on, readers of that architectural register get this tag.
- R4: In the same cycle, `oldPhys` shows the physical register the destination mapped to before the update.
- R5: When the pool is empty, `renReady` is low for an instruction with a destination. A `renValid` then changes neither the map nor the pool.
- R6: A commit release (`cmtValid`, `cmtPhys`) returns that physical register to the pool from the next cycle on.
- R7: A squash step (`sqValid`) writes `sqOldPhys` back into the map entry `sqArch` and returns `sqNewPhys` to the pool, both from the next cycle on.
- R8: While `sqValid` is high, `renReady` is low and no rename takes place.
- R9: An instruction with `renHasDst` low takes no register from the pool, drives `dstPhys` as 0, and is accepted even when the pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | An instruction is presented for renaming |
| renSrcA | input | $clog2(ARCH_REGS) | First source architectural register |
| renSrcB | input | $clog2(ARCH_REGS) | Second source architectural register |
| renDst | input | $clog2(ARCH_REGS) | Destination architectural register |
| renHasDst | input | 1 | The instruction writes a register |
| renReady | output | 1 | The presented instruction can be renamed this cycle |
| srcAPhys | output | $clog2(PHYS_REGS) | Physical tag of the first source |
| srcBPhys | output | $clog2(PHYS_REGS) | Physical tag of the second source |
| dstPhys | output | $clog2(PHYS_REGS) | Newly allocated destination tag (0 when no destination) |
| oldPhys | output | $clog2(PHYS_REGS) | Previous mapping of the destination |
| cmtValid | input | 1 | Release one physical register at commit |
| cmtPhys | input | $clog2(PHYS_REGS) | Register released at commit |
| sqValid | input | 1 | Apply one squash step |
| sqArch | input | $clog2(ARCH_REGS) | Architectural register to restore |
| sqOldPhys | input | $clog2(PHYS_REGS) | Mapping to put back |
| sqNewPhys | input | $clog2(PHYS_REGS) | Register of the squashed instruction to free |

## Verification
The main rename path is driven with a dependent chain: a write, a read of that write, and a second write to the same name. This shows that consumers follow the newest version and that each write gets a fresh tag. A read-and-write of the same register separates lookup-before-update from lookup-after-update. Repeated writes to one register until the pool runs dry show the lowest-free allocation order, the stall, and the fact that instructions without a destination still pass. A youngest-first squash replay followed by a commit release shows that the map returns to its old state and that released tags are handed out again.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Strobes from the control to the map datapath.
  typedef struct packed {
    logic renFire;    // instruction accepted this cycle
    logic allocFire;  // accepted and takes a new register
    logic sqFire;     // squash step applied this cycle
  } renStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renValid,
  input  logic          renHasDst,
  input  logic          cmtValid,
  input  logic [PW-1:0] cmtPhys,
  input  logic          sqValid,
  input  logic [PW-1:0] sqNewPhys,
  output logic          renReady,
  output logic [PW-1:0] newTag,
  output renStrobe_t    strobe
);
  logic [PHYS_REGS-1:0] freeVec;
  logic [PHYS_REGS-1:0] freeNext;
  logic                 freeAny;

  // Lowest-numbered free register wins.
  always_comb begin
    newTag = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (freeVec[i]) newTag = PW'(i);
    end
  end

  assign freeAny  = |freeVec;
  assign renReady = !sqValid && (freeAny || !renHasDst);

  always_comb begin
    strobe.renFire   = renValid && renReady;
    strobe.allocFire = renValid && renReady && renHasDst;
    strobe.sqFire    = sqValid;
  end

  always_comb begin
    freeNext = freeVec;
    if (strobe.allocFire) freeNext[newTag] = 1'b0;
    if (cmtValid)         freeNext[cmtPhys] = 1'b1;
    if (strobe.sqFire)    freeNext[sqNewPhys] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++) freeVec[i] <= (i >= ARCH_REGS);
    end else begin
      freeVec <= freeNext;
    end
  end

  // R3: the register handed out leaves the pool at the next edge
  p_alloc_taken_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocFire |=> !freeVec[$past(newTag)]);
  // R5: empty pool blocks any instruction that needs a register
  p_stall_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (freeVec == '0 && renHasDst) |-> !renReady);
  // R6: a commit may only release a register that is in use
  p_no_double_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |-> !freeVec[cmtPhys]);
  // R6: a released register is free one cycle later
  p_release_seen_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |=> freeVec[$past(cmtPhys)]);
  // R7: a squash may only free a register that is in use
  p_sq_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |-> !freeVec[sqNewPhys]);
  // R8: no rename during a squash step
  p_sq_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    sqValid |-> !strobe.renFire);
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  renStrobe_t    strobe,
  input  logic [PW-1:0] newTag,
  input  logic [AW-1:0] renSrcA,
  input  logic [AW-1:0] renSrcB,
  input  logic [AW-1:0] renDst,
  input  logic [AW-1:0] sqArch,
  input  logic [PW-1:0] sqOldPhys,
  output logic [PW-1:0] srcAPhys,
  output logic [PW-1:0] srcBPhys,
  output logic [PW-1:0] dstPhys,
  output logic [PW-1:0] oldPhys
);
  logic [PW-1:0] mapTab [ARCH_REGS];

  // Lookups use the table as registered, before this instruction's write.
  assign srcAPhys = mapTab[renSrcA];
  assign srcBPhys = mapTab[renSrcB];
  assign oldPhys  = mapTab[renDst];
  assign dstPhys  = strobe.allocFire ? newTag : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARCH_REGS; i++) mapTab[i] <= PW'(i);
    end else if (strobe.sqFire) begin
      mapTab[sqArch] <= sqOldPhys;
    end else if (strobe.allocFire) begin
      mapTab[renDst] <= newTag;
    end
  end

  // R3: the destination entry holds the new tag after the edge
  p_map_update_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocFire |=> mapTab[$past(renDst)] == $past(newTag));
  // R4: the new tag never equals the displaced one
  p_fresh_tag_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocFire |-> dstPhys != oldPhys);
  // R7: a squash step restores the saved mapping
  p_restore_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sqFire |=> mapTab[$past(sqArch)] == $past(sqOldPhys));
  // R5: without an accepted rename or squash the table stays put
  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.allocFire && !strobe.sqFire) |=> mapTab[$past(renDst)] == $past(oldPhys));
endmodule

// File: rtl/rename_map.sv
module rename_map
  import rename_pkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 16,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renValid,
  input  logic [AW-1:0] renSrcA,
  input  logic [AW-1:0] renSrcB,
  input  logic [AW-1:0] renDst,
  input  logic          renHasDst,
  output logic          renReady,
  output logic [PW-1:0] srcAPhys,
  output logic [PW-1:0] srcBPhys,
  output logic [PW-1:0] dstPhys,
  output logic [PW-1:0] oldPhys,
  input  logic          cmtValid,
  input  logic [PW-1:0] cmtPhys,
  input  logic          sqValid,
  input  logic [AW-1:0] sqArch,
  input  logic [PW-1:0] sqOldPhys,
  input  logic [PW-1:0] sqNewPhys
);
  renStrobe_t    strobe;
  logic [PW-1:0] newTag;

  rename_ctrl #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renHasDst(renHasDst),
    .cmtValid(cmtValid), .cmtPhys(cmtPhys), .sqValid(sqValid),
    .sqNewPhys(sqNewPhys), .renReady(renReady), .newTag(newTag),
    .strobe(strobe)
  );

  rename_datapath #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newTag(newTag),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst),
    .sqArch(sqArch), .sqOldPhys(sqOldPhys),
    .srcAPhys(srcAPhys), .srcBPhys(srcBPhys), .dstPhys(dstPhys),
    .oldPhys(oldPhys)
  );
endmodule

// File: tb/rename_map_tb.sv
module rename_map_tb;
  localparam int ARCH_REGS = 8;
  localparam int PHYS_REGS = 16;
  localparam int AW = $clog2(ARCH_REGS);
  localparam int PW = $clog2(PHYS_REGS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic renValid = 1'b0, renHasDst = 1'b0, renReady;
  logic [AW-1:0] renSrcA = '0, renSrcB = '0, renDst = '0, sqArch = '0;
  logic [PW-1:0] srcAPhys, srcBPhys, dstPhys, oldPhys;
  logic cmtValid = 1'b0, sqValid = 1'b0;
  logic [PW-1:0] cmtPhys = '0, sqOldPhys = '0, sqNewPhys = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rename_map #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one instruction, check combinational outputs, then clock it.
  task automatic ren(input int a, input int b, input int d, input bit hasD,
                     input int eA, input int eB, input int eNew, input int eOld,
                     input bit eRdy, input string req);
    @(negedge clk);
    renValid = 1'b1; renSrcA = AW'(a); renSrcB = AW'(b);
    renDst = AW'(d); renHasDst = hasD;
    #1;
    chk({req, " ready"}, int'(renReady), int'(eRdy));
    chk({req, " srcA"}, int'(srcAPhys), eA);
    chk({req, " srcB"}, int'(srcBPhys), eB);
    if (hasD) chk({req, " old"}, int'(oldPhys), eOld);
    chk({req, " new"}, int'(dstPhys), eNew);
    @(posedge clk); #1;
    renValid = 1'b0; renHasDst = 1'b0;
  endtask

  task automatic squashStep(input int arch, input int oldP, input int newP);
    @(negedge clk);
    sqValid = 1'b1; sqArch = AW'(arch); sqOldPhys = PW'(oldP); sqNewPhys = PW'(newP);
    @(posedge clk); #1;
    sqValid = 1'b0;
  endtask

  task automatic t_reset();
    // R1: identity map; R9: no destination, no allocation
    ren(3, 5, 0, 1'b0, 3, 5, 0, 0, 1'b1, "R1 R9 identity");
    ren(0, 7, 0, 1'b0, 0, 7, 0, 0, 1'b1, "R1 identity edges");
  endtask

  task automatic t_chain();
    // add r1,r2,# : first free is 8 (R1, R3), old r1 = 1 (R4)
    ren(2, 2, 1, 1'b1, 2, 2, 8, 1, 1'b1, "R3 R4 first write");
    // add r3,r1,r1 : reads newest r1 = 8
    ren(1, 1, 3, 1'b1, 8, 8, 9, 3, 1'b1, "R3 consumer sees new version");
    // sub r1,r2,r2 : another fresh tag, old = 8
    ren(2, 2, 1, 1'b1, 2, 2, 10, 8, 1'b1, "R3 R4 second write r1");
    // add r4,r4,r4 : source sees old mapping
    ren(4, 4, 4, 1'b1, 4, 4, 11, 4, 1'b1, "R2 same reg read/write");
  endtask

  task automatic t_squash();
    // R8: rename blocked while squashing
    @(negedge clk);
    sqValid = 1'b1; sqArch = AW'(4); sqOldPhys = PW'(4); sqNewPhys = PW'(11);
    renValid = 1'b1; renHasDst = 1'b1; renDst = AW'(6); renSrcA = AW'(4);
    #1;
    chk("R8 ready low in squash", int'(renReady), 0);
    chk("R8 no tag in squash", int'(dstPhys), 0);
    @(posedge clk); #1;
    sqValid = 1'b0; renValid = 1'b0; renHasDst = 1'b0;
    squashStep(1, 8, 10);
    squashStep(3, 3, 9);
    squashStep(1, 1, 8);
    // R7: map restored; R8: r6 untouched
    ren(1, 3, 0, 1'b0, 1, 3, 0, 0, 1'b1, "R7 restored r1 r3");
    ren(4, 6, 0, 1'b0, 4, 6, 0, 0, 1'b1, "R7 R8 restored r4 r6");
  endtask

  task automatic t_empty();
    // R7 returned 8..11; allocate 8..15 to r5 in order
    for (int k = 0; k < 8; k++)
      ren(5, 5, 5, 1'b1, (k == 0) ? 5 : 7 + k, (k == 0) ? 5 : 7 + k,
          8 + k, (k == 0) ? 5 : 7 + k, 1'b1, "R3 R7 lowest free order");
    // R5: pool empty, stall
    ren(5, 5, 6, 1'b1, 15, 15, 0, 6, 1'b0, "R5 stall when empty");
    // R5: r6 unchanged; R9: no-dst passes while empty
    ren(6, 5, 0, 1'b0, 6, 15, 0, 0, 1'b1, "R5 R9 map held, no-dst accepted");
  endtask

  task automatic t_commit();
    @(negedge clk);
    cmtValid = 1'b1; cmtPhys = PW'(5);
    @(posedge clk); #1;
    cmtValid = 1'b0;
    // R6: released register 5 handed out next
    ren(6, 6, 6, 1'b1, 6, 6, 5, 6, 1'b1, "R6 released tag reused");
    ren(6, 6, 7, 1'b1, 5, 5, 0, 7, 1'b0, "R6 R5 empty again");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(renReady), 1);
    t_reset();
    t_chain();
    t_squash();
    t_empty();
    t_commit();
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule